// File: doc/BRIEF.md
# Touch Screen ADC Serial Host Controller

This block is the host side of a four-wire synchronous serial link to a touch-screen digitizer ADC. When the system asks for a sample, the controller pulls the active-low chip select down and sends a control byte that names one of four input channels and the resolution. It then keeps the serial clock running through the converter's busy cycle and its conversion cycles, and shifts in an 8-bit or 12-bit straight-binary result. When the frame ends it raises chip select and presents the result together with a one-cycle done pulse.

The converter has no clock of its own: each serial clock cycle is one step of its acquisition and conversion. So the controller does not simply move a byte. It counts the exact number of rising edges after the start bit and samples the data line only on the edges that carry result bits. The serial clock comes from a system-clock divider that is set by a parameter. Each clock phase lasts `DIV_HALF` system cycles, and the parameters must make that at least 200 ns.

Top module: `tad_host`

## Requirements
- R1: While reset is held and in the cycle after it, `adc_cs_n` is 1, `adc_sclk` is 0, `done` is 0 and `result` is 0.
- R2: A `start` pulse is accepted only while no frame is in progress. A `start` seen during a frame changes neither the channel, the resolution nor the result of that frame, and it never opens a second frame.
- R3: The control byte is sent MSB first, and `adc_sdi` changes only while `adc_sclk` is low. Its layout is bit 7 = 1 (start bit), bit 6 = 0, bits 5:4 = `chan`, bit 3 = `short_res` (1 selects 8 bits), bits 2:0 = 0.
- R4: `adc_sclk` is low when `adc_cs_n` falls, and the first rising clock edge comes at least `DIV_HALF` system cycles later.
- R5: Every high phase and every low phase of `adc_sclk` inside a frame lasts at least `DIV_HALF` system cycles, which is at least 200 ns at the default system clock.
- R6: In 12-bit mode a frame has 21 rising clock edges: 8 for the control byte, 1 for the busy cycle, then 12 edges on which `adc_sdo` is sampled MSB first. The straight-binary result appears unchanged on `result`.
- R7: In 8-bit mode a frame has 17 rising edges: the last 8 carry the result, which appears on `result[7:0]` with `result[11:8]` = 0.
- R8: `done` is high for exactly one system cycle per frame, in the cycle where `result` first shows the new value, and `adc_cs_n` is already high in that cycle.
- R9: `adc_sdo` is ignored while `adc_cs_n` is high. Toggling it between frames changes neither `result` nor `done`.
- R10: `adc_sclk` stays low whenever `adc_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion frame |
| chan | input | 2 | Input channel to convert |
| short_res | input | 1 | 1 selects 8-bit result, 0 selects 12-bit |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock, also the converter's conversion clock |
| adc_sdi | output | 1 | Serial control data, sampled by the converter on rising edges |
| adc_sdo | input | 1 | Serial result data, launched by the converter on falling edges |
| result | output | 12 | Last converted value, right-aligned |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench sweeps every channel at both resolutions with all-zero, all-one and mixed per-channel codes from a converter model that counts rising clock edges by itself. A controller whose edge count is off by one would capture a shifted word or a stray trailing bit. A wrong channel or resolution field shows up both in the control byte the model receives and in which code comes back. The bench also sends a start in the middle of a frame, which must not change the frame or add a second done, and toggles the data line between frames, which must not reach the result. It measures the chip-select setup time and every clock phase against the divider, so a controller that emits a short phase or raises the clock too soon after chip select falls is reported.

// File: rtl/tad_pkg.sv
package tad_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETUP,
    S_RUN,
    S_TAIL
  } tad_state_e;

  // Control bits plus one busy cycle precede the first result bit.
  localparam int CTRL_BITS  = 8;
  localparam int LEAD_EDGES = CTRL_BITS + 1;

  // bit7 start, bit6 zero, bits5:4 channel, bit3 short resolution, bits2:0 zero
  function automatic logic [CTRL_BITS-1:0] tad_ctrl_byte(input logic [1:0] chan,
                                                        input logic       short_res);
    return {1'b1, 1'b0, chan, short_res, 3'b000};
  endfunction

endpackage

// File: rtl/tad_phase.sv
module tad_phase #(
  parameter int DIV_HALF = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && (cnt_q == LAST);

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/tad_capture.sv
module tad_capture #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [RES_W-1:0] data
);
  logic [RES_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr) sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[RES_W-2:0], bit_in};
  end

  assign data = sh_q;

endmodule

// File: rtl/tad_seq.sv
module tad_seq
  import tad_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] chan,
  input  logic       short_res,
  input  logic       tick,
  output logic       phase_en,
  output logic       cs_n,
  output logic       sclk,
  output logic       sdi,
  output logic       cap_clr,
  output logic       cap_shift,
  output logic       fin
);
  localparam int EW = $clog2(LEAD_EDGES + RES_W + 1);
  localparam logic [EW-1:0] EDGES_LONG  = EW'(LEAD_EDGES + RES_W);
  localparam logic [EW-1:0] EDGES_SHORT = EW'(LEAD_EDGES + SHORT_W);
  localparam logic [EW-1:0] LEAD_CNT    = EW'(LEAD_EDGES);

  tad_state_e           state_q;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [EW-1:0]        edge_q;
  logic                 short_q;
  logic                 cs_n_q;
  logic                 sclk_q;
  logic [EW-1:0]        last_edge;

  assign last_edge = short_q ? EDGES_SHORT : EDGES_LONG;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      edge_q  <= '0;
      short_q <= 1'b0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          ctrl_q  <= tad_ctrl_byte(chan, short_res);
          short_q <= short_res;
          edge_q  <= '0;
          cs_n_q  <= 1'b0;
          state_q <= S_SETUP;
        end
        S_SETUP: if (tick) begin
          sclk_q  <= 1'b1;
          edge_q  <= EW'(1);
          state_q <= S_RUN;
        end
        S_RUN: if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            ctrl_q <= {ctrl_q[CTRL_BITS-2:0], 1'b0};
            if (edge_q == last_edge) state_q <= S_TAIL;
          end else begin
            sclk_q <= 1'b1;
            edge_q <= edge_q + 1'b1;
          end
        end
        S_TAIL: if (tick) begin
          cs_n_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign phase_en  = (state_q != S_IDLE);
  assign cs_n      = cs_n_q;
  assign sclk      = sclk_q;
  assign sdi       = ctrl_q[CTRL_BITS-1];
  assign cap_clr   = (state_q == S_IDLE) && start;
  assign cap_shift = (state_q == S_RUN) && tick && !sclk_q && (edge_q >= LEAD_CNT);
  assign fin       = (state_q == S_TAIL) && tick;

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> $stable(short_q));

  // R3
  sdi_stable_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_q) |-> $stable(sdi));

  // R4
  cs_fall_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> !sclk_q);

endmodule

// File: rtl/tad_host.sv
module tad_host #(
  parameter int RES_W        = 12,
  parameter int SHORT_W      = 8,
  parameter int DIV_HALF     = 25,
  parameter int SYS_NS       = 10,
  parameter int MIN_PHASE_NS = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       chan,
  input  logic             short_res,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_sdi,
  input  logic             adc_sdo,
  output logic [RES_W-1:0] result,
  output logic             done
);
  localparam int MIN_CYC = (MIN_PHASE_NS + SYS_NS - 1) / SYS_NS;
  localparam int HW      = $clog2(MIN_CYC + 1);

  logic             tick, phase_en, cap_clr, cap_shift, fin;
  logic [RES_W-1:0] cap_data;
  logic [RES_W-1:0] result_q;
  logic             done_q;

  tad_phase #(.DIV_HALF(DIV_HALF)) u_phase (
    .clk(clk), .rst(rst), .en(phase_en), .tick(tick)
  );

  tad_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .chan(chan), .short_res(short_res),
    .tick(tick), .phase_en(phase_en), .cs_n(adc_cs_n), .sclk(adc_sclk),
    .sdi(adc_sdi), .cap_clr(cap_clr), .cap_shift(cap_shift), .fin(fin)
  );

  tad_capture #(.RES_W(RES_W)) u_cap (
    .clk(clk), .rst(rst), .clr(cap_clr), .shift_en(cap_shift),
    .bit_in(adc_sdo), .data(cap_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) result_q <= cap_data;
    end
  end

  assign result = result_q;
  assign done   = done_q;

  // Independent phase-length monitor for the pulse-width rule.
  logic          sclk_d;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      hold_q <= '0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_sclk != sclk_d) hold_q <= HW'(1);
      else if (hold_q != HW'(MIN_CYC)) hold_q <= hold_q + 1'b1;
    end
  end

  // R5
  min_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_sclk != sclk_d) |-> (hold_q >= HW'(MIN_CYC)));

  // R10
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_sclk);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> adc_cs_n);

  // R9
  no_idle_sample_chk: assert property (@(posedge clk) disable iff (rst)
    cap_shift |-> !adc_cs_n);

endmodule

// File: tb/test_tad_host.sv
module test_tad_host;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  chan = 2'd0;
  logic        short_res = 1'b0;
  logic        adc_cs_n, adc_sclk, adc_sdi;
  wire         adc_sdo;
  logic [11:0] result;
  logic        done;

  always #(CLK_PERIOD/2) clk = ~clk;

  tad_host #(.DIV_HALF(DIV_HALF)) i_tad_host (
    .clk(clk), .rst(rst), .start(start), .chan(chan), .short_res(short_res),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdi(adc_sdi),
    .adc_sdo(adc_sdo), .result(result), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Converter model
  logic [11:0] chan_val [4];
  int          rcnt = 0;
  int          kbit;
  int          nbits;
  logic [7:0]  cap = 8'h00;
  logic [11:0] mval;
  logic        model_bit = 1'b0;
  logic        junk = 1'b0;
  logic        junk_en = 1'b0;

  always @(negedge adc_cs_n) begin
    rcnt = 0;
    cap  = 8'h00;
  end

  always @(posedge adc_sclk) begin
    if (!adc_cs_n) begin
      rcnt = rcnt + 1;
      if (rcnt <= 8) cap = {cap[6:0], adc_sdi};
    end
  end

  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      kbit  = rcnt - 9;
      nbits = cap[3] ? 8 : 12;
      mval  = cap[3] ? {4'h0, chan_val[cap[5:4]][11:4]} : chan_val[cap[5:4]];
      if (kbit >= 0 && kbit < nbits) model_bit = mval[nbits-1-kbit];
      else model_bit = 1'b0;
    end
  end

  always @(posedge clk) if (junk_en) junk <= ~junk;

  assign adc_sdo = adc_cs_n ? junk : model_bit;

  // Monitor, sampled away from the active edge
  int cyc = 0, fall_cyc = 0, last_tog = 0, setup_len = 0, min_phase = 0;
  int rises = 0, done_cnt = 0, done_wide = 0, idle_sclk = 0;
  bit first_seen = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !adc_cs_n) begin
        fall_cyc = cyc; last_tog = cyc; rises = 0; first_seen = 0;
      end
      if (adc_sclk != prev_sclk && !adc_cs_n) begin
        if (cyc - last_tog < min_phase) min_phase = cyc - last_tog;
        last_tog = cyc;
        if (adc_sclk) begin
          rises++;
          if (!first_seen) begin
            setup_len = cyc - fall_cyc;
            first_seen = 1;
          end
        end
      end
      if (adc_cs_n && adc_sclk) idle_sclk++;
      if (done) done_cnt++;
      if (done && prev_done) done_wide++;
      prev_cs = adc_cs_n; prev_sclk = adc_sclk; prev_done = done;
    end
    cyc++;
  end

  task automatic pulse_start(input logic [1:0] c, input logic r);
    @(negedge clk);
    chan = c; short_res = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin
        chk(adc_cs_n == 1'b1, "R8 cs_n high with done", int'(adc_cs_n), 1);
        break;
      end
    end
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [11:0] expect_val(input logic [1:0] c, input logic r);
    return r ? {4'h0, chan_val[c][11:4]} : chan_val[c];
  endfunction

  task automatic run_frame(input logic [1:0] c, input logic r);
    int d0;
    logic [11:0] ev;
    min_phase = 1000000;
    d0 = done_cnt;
    done_wide = 0;
    pulse_start(c, r);
    wait_done();
    ev = expect_val(c, r);
    chk(cap == {1'b1, 1'b0, c, r, 3'b000}, "R3 control byte", int'(cap),
        int'({1'b1, 1'b0, c, r, 3'b000}));
    if (r) begin
      chk(result == ev, "R7 8-bit result", int'(result), int'(ev));
      chk(rises == 17, "R7 rising edges", rises, 17);
    end else begin
      chk(result == ev, "R6 12-bit result", int'(result), int'(ev));
      chk(rises == 21, "R6 rising edges", rises, 21);
    end
    chk(setup_len >= DIV_HALF, "R4 cs setup cycles", setup_len, DIV_HALF);
    chk(min_phase >= DIV_HALF, "R5 min phase cycles", min_phase, DIV_HALF);
    chk(done_cnt - d0 == 1 && done_wide == 0, "R8 done pulses", done_cnt - d0, 1);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) chan_val[k] = 12'h000;
    repeat (4) @(negedge clk);
    // r1_ reset values
    chk(adc_cs_n == 1'b1, "R1 cs_n in reset", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R1 sclk in reset", int'(adc_sclk), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(result == 12'h000, "R1 result in reset", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0 && done == 1'b0 && result == 12'h000,
        "R1 after reset", int'({adc_cs_n, adc_sclk, done}), 4);

    // Sweep: pattern x resolution x channel
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        case (p)
          0: chan_val[k] = {k[1:0], 10'h000};
          1: chan_val[k] = ~{k[1:0], 10'h000};
          default: chan_val[k] = 12'(k * 12'h3A7 + 12'h0C5);
        endcase
      end
      for (int r = 0; r < 2; r++) begin
        for (int c = 0; c < 4; c++) run_frame(c[1:0], r[0]);
      end
    end

    // R2: start during a frame is ignored
    begin
      int d0;
      logic [11:0] ev;
      d0 = done_cnt;
      pulse_start(2'd1, 1'b0);
      repeat (300) @(negedge clk);
      pulse_start(2'd2, 1'b1);
      wait_done();
      ev = expect_val(2'd1, 1'b0);
      chk(cap == 8'b1001_0000, "R2 control byte kept", int'(cap), 8'h90);
      chk(result == ev, "R2 result kept", int'(result), int'(ev));
      repeat (2000) @(negedge clk);
      chk(done_cnt - d0 == 1, "R2 no second frame", done_cnt - d0, 1);
      chk(adc_cs_n == 1'b1, "R2 idle after frame", int'(adc_cs_n), 1);
    end

    // R9: data line toggling between frames is ignored
    begin
      int d0;
      logic [11:0] r0;
      d0 = done_cnt;
      r0 = result;
      junk_en = 1'b1;
      repeat (400) @(negedge clk);
      junk_en = 1'b0;
      chk(result == r0, "R9 result unchanged", int'(result), int'(r0));
      chk(done_cnt == d0, "R9 no done", done_cnt - d0, 0);
    end

    // R10: clock never high with chip select high
    chk(idle_sclk == 0, "R10 idle clock", idle_sclk, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule